// File: doc/BRIEF.md
# DRAM Row, Column and Bank Mapper

This block turns a rank-local byte address into the DRAM coordinates of one DIMM: row, column, bank address and bank group. The DIMM's setup arrives on plain configuration pins. These pins give the page policy (closed or open), whether fine-grain bank interleave is on, whether XOR bank hashing is on, and how many row and column bits the device has. Row and column bits are picked from fixed address bit positions. The positions differ between closed-page, open-page and open-page fine-grain modes. The two bank fields each take two address bits and can be hashed with two more.

Addresses stream in over a valid/ready interface, and results stream out the same way. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so `in_ready = !out_valid || out_ready`. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the outputs with `out_valid` one clock later. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new beat is accepted. The configuration pins are sampled together with the address of the accepted beat.

Top module: `drm_rcb_mapper`

## Requirements
- R1: In closed-page mode, row bit i (i = 0..16) is address bit 15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33 taken in that index order.
- R2: In closed-page mode, column bits 0..9 are address bits 3,4,5,14,19,23,24,25,26,27 in index order, and column bit 10 (auto-precharge request) is always 1; fine-grain mode has no effect on the closed-page mapping.
- R3: In closed-page mode, bank = {addr[9], addr[8]} and bank group = {addr[7], addr[6]}. When hashing is on, they are XORed with {addr[28], addr[22]} and {addr[21], addr[20]} respectively.
- R4: In open-page mode, row bit i is address bit 14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33 in index order.
- R5: In open-page mode, column bits 0..9 are address bits 3..12 in order, or 3,4,5,7,8,9,10,11,12,13 when fine-grain is on; column bit 10 is 0.
- R6: In open-page mode, bank = {addr[19], addr[18]}, XORed with {addr[23], addr[22]} when hashing is on.
- R7: In open-page mode, bank group = {addr[17], addr[6]} with fine-grain on and {addr[17], addr[13]} with it off, XORed with {addr[21], addr[20]} when hashing is on.
- R8: Row bit i is nonzero only when i is below the configured row bit count (normally 13 to 18). Row bit 17, which has no listed position, is always 0.
- R9: Column bit i (0..9) is nonzero only when i is below the configured column count; counts above 10 gather all 10 listed positions.
- R10: An accepted beat gives `out_valid` on the next clock, and `in_ready` equals `!out_valid || out_ready`.
- R11: While `out_valid` is high and `out_ready` is low, all output fields and `out_valid` stay unchanged.
- R12: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address beat valid |
| in_ready | output | 1 | Mapper can accept a beat |
| in_addr | input | 34 | Rank-local address |
| cfg_closed_page | input | 1 | 1 = closed-page policy, 0 = open-page |
| cfg_fine_grain | input | 1 | Fine-grain bank interleave (open-page only) |
| cfg_bank_xor | input | 1 | Enable XOR bank hashing |
| cfg_row_bits | input | 5 | Number of row bits of the device |
| cfg_col_bits | input | 4 | Number of column bits of the device |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_row | output | 18 | Row number |
| out_col | output | 11 | Column number, bit 10 = auto-precharge |
| out_bank | output | 2 | Bank address |
| out_bgrp | output | 2 | Bank group |

## Verification
The bench drives random addresses, together with configurations that change on every beat and random back-pressure. Each field is compared against a table-driven model. If a design swapped two positions in one list, the wrong row or column bit would show up under random data. If it mixed the open and fine-grain lists, the column would be off only when fine-grain is on. Directed beats cover the remaining corners. An all-ones address with the largest counts exposes a design that fills row bit 17 or lets the column count go past 10. Addresses that set only the hash bits show whether the XOR operands are taken from the right bits for each policy. A design that changed its outputs under a stall, or accepted a beat while full, would fail both the hold comparison and the order of the result queue.

// File: rtl/drm_map_pkg.sv
package drm_map_pkg;

  typedef enum logic [1:0] {
    PG_CLOSED    = 2'd0,
    PG_OPEN      = 2'd1,
    PG_OPEN_FINE = 2'd2
  } page_mode_e;

  localparam int ROW_LIST_LEN = 17;
  localparam int COL_LIST_LEN = 10;

  // Address bit feeding row bit i for a given page mode.
  function automatic int row_src(page_mode_e m, int i);
    int p;
    if (m == PG_CLOSED) begin
      if (i < 4)       p = 15 + i;
      else if (i < 7)  p = 16 + i;
      else if (i == 7) p = 28;
      else if (i < 12) p = i + 2;
      else             p = 17 + i;
    end else begin
      if (i < 3)       p = 14 + i;
      else if (i == 3) p = 20;
      else if (i == 4) p = 28;
      else if (i < 12) p = 16 + i;
      else             p = 17 + i;
    end
    return p;
  endfunction

  // Address bit feeding column bit i for a given page mode.
  function automatic int col_src(page_mode_e m, int i);
    int p;
    if (m == PG_CLOSED) begin
      if (i < 3)       p = 3 + i;
      else if (i == 3) p = 14;
      else if (i == 4) p = 19;
      else             p = 18 + i;
    end else if (m == PG_OPEN_FINE) begin
      if (i < 3)       p = 3 + i;
      else             p = 4 + i;
    end else begin
      p = 3 + i;
    end
    return p;
  endfunction

endpackage

// File: rtl/drm_bit_gather.sv
module drm_bit_gather
  import drm_map_pkg::*;
#(
  parameter int ADDR_W   = 34,
  parameter int OUT_W    = 18,
  parameter int LIST_LEN = 17,
  parameter int CNT_W    = 5,
  parameter bit IS_ROW   = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  page_mode_e        mode,
  input  logic [CNT_W-1:0]  count,
  output logic [OUT_W-1:0]  field
);

  logic unused_addr_bits;
  assign unused_addr_bits = ^addr;

  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    if (i < LIST_LEN) begin : g_used
      localparam int P_CL = IS_ROW ? row_src(PG_CLOSED, i)    : col_src(PG_CLOSED, i);
      localparam int P_OP = IS_ROW ? row_src(PG_OPEN, i)      : col_src(PG_OPEN, i);
      localparam int P_OF = IS_ROW ? row_src(PG_OPEN_FINE, i) : col_src(PG_OPEN_FINE, i);
      logic src;
      logic keep;
      always_comb begin
        unique case (mode)
          PG_CLOSED: src = addr[P_CL];
          PG_OPEN:   src = addr[P_OP];
          default:   src = addr[P_OF];
        endcase
      end
      assign keep     = (count > CNT_W'(i));
      assign field[i] = src & keep;
    end else begin : g_pad
      assign field[i] = 1'b0;
    end
  end

endmodule

// File: rtl/drm_bank_hash.sv
module drm_bank_hash
  import drm_map_pkg::*;
#(
  parameter int ADDR_W = 34
) (
  input  logic [ADDR_W-1:0] addr,
  input  page_mode_e        mode,
  input  logic              xor_en,
  output logic [1:0]        bank,
  output logic [1:0]        bgrp
);

  logic unused_addr_bits;
  assign unused_addr_bits = ^addr;

  logic [1:0] bank_raw, bank_key;
  logic [1:0] bgrp_raw, bgrp_key;

  always_comb begin
    bgrp_key = {addr[21], addr[20]};
    if (mode == PG_CLOSED) begin
      bank_raw = {addr[9], addr[8]};
      bank_key = {addr[28], addr[22]};
      bgrp_raw = {addr[7], addr[6]};
    end else begin
      bank_raw = {addr[19], addr[18]};
      bank_key = {addr[23], addr[22]};
      bgrp_raw = {addr[17], (mode == PG_OPEN_FINE) ? addr[6] : addr[13]};
    end
  end

  assign bank = bank_raw ^ (bank_key & {2{xor_en}});
  assign bgrp = bgrp_raw ^ (bgrp_key & {2{xor_en}});

endmodule

// File: rtl/drm_pipe_reg.sv
module drm_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

endmodule

// File: rtl/drm_rcb_mapper.sv
module drm_rcb_mapper
  import drm_map_pkg::*;
#(
  parameter int ADDR_W    = 34,
  parameter int ROW_W     = 18,
  parameter int ROW_CNT_W = 5,
  parameter int COL_CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic                 cfg_closed_page,
  input  logic                 cfg_fine_grain,
  input  logic                 cfg_bank_xor,
  input  logic [ROW_CNT_W-1:0] cfg_row_bits,
  input  logic [COL_CNT_W-1:0] cfg_col_bits,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ROW_W-1:0]     out_row,
  output logic [COL_LIST_LEN:0] out_col,
  output logic [1:0]           out_bank,
  output logic [1:0]           out_bgrp
);

  localparam int COL_W  = COL_LIST_LEN + 1;
  localparam int DATA_W = ROW_W + COL_W + 4;

  page_mode_e              mode;
  logic [ROW_W-1:0]        row_c;
  logic [COL_LIST_LEN-1:0] col_c;
  logic [1:0]              bank_c, bgrp_c;
  logic [DATA_W-1:0]       pack_c, pack_q;

  always_comb begin
    if (cfg_closed_page)     mode = PG_CLOSED;
    else if (cfg_fine_grain) mode = PG_OPEN_FINE;
    else                     mode = PG_OPEN;
  end

  drm_bit_gather #(
    .ADDR_W(ADDR_W), .OUT_W(ROW_W), .LIST_LEN(ROW_LIST_LEN),
    .CNT_W(ROW_CNT_W), .IS_ROW(1'b1)
  ) u_row (
    .addr(in_addr), .mode(mode), .count(cfg_row_bits), .field(row_c)
  );

  drm_bit_gather #(
    .ADDR_W(ADDR_W), .OUT_W(COL_LIST_LEN), .LIST_LEN(COL_LIST_LEN),
    .CNT_W(COL_CNT_W), .IS_ROW(1'b0)
  ) u_col (
    .addr(in_addr), .mode(mode), .count(cfg_col_bits), .field(col_c)
  );

  drm_bank_hash #(.ADDR_W(ADDR_W)) u_bank (
    .addr(in_addr), .mode(mode), .xor_en(cfg_bank_xor),
    .bank(bank_c), .bgrp(bgrp_c)
  );

  // Auto-precharge request sits above the gathered column bits.
  assign pack_c = {row_c, cfg_closed_page, col_c, bank_c, bgrp_c};

  drm_pipe_reg #(.W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(pack_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pack_q)
  );

  assign {out_row, out_col, out_bank, out_bgrp} = pack_q;

endmodule

// File: rtl/drm_rcb_mapper_chk.sv
module drm_rcb_mapper_chk #(
  parameter int ADDR_W    = 34,
  parameter int ROW_W     = 18,
  parameter int ROW_CNT_W = 5,
  parameter int COL_CNT_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [ADDR_W-1:0]    in_addr,
  input logic                 cfg_closed_page,
  input logic                 cfg_fine_grain,
  input logic                 cfg_bank_xor,
  input logic [ROW_CNT_W-1:0] cfg_row_bits,
  input logic [COL_CNT_W-1:0] cfg_col_bits,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [ROW_W-1:0]     out_row,
  input logic [10:0]          out_col,
  input logic [1:0]           out_bank,
  input logic [1:0]           out_bgrp
);

  logic unused_chk;
  assign unused_chk = ^{in_addr, cfg_fine_grain, cfg_bank_xor};

  p_accept_then_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_no_accept_stalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_col)
                                   && $stable(out_bank) && $stable(out_bgrp)));

  p_autopre_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cfg_closed_page) |=> out_col[10]);

  p_autopre_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !cfg_closed_page) |=> !out_col[10]);

  p_row_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((out_row >> $past(cfg_row_bits)) == '0));

  p_col_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (cfg_col_bits < 4'd10))
      |=> ((out_col[9:0] >> $past(cfg_col_bits)) == '0));

  p_idle_after_reset_r12: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

bind drm_rcb_mapper drm_rcb_mapper_chk #(
  .ADDR_W(ADDR_W), .ROW_W(ROW_W), .ROW_CNT_W(ROW_CNT_W), .COL_CNT_W(COL_CNT_W)
) u_chk (.*);

// File: tb/test_drm_rcb_mapper.sv
`timescale 1ns/1ps
module test_drm_rcb_mapper;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [33:0] in_addr;
  logic        cfg_closed_page, cfg_fine_grain, cfg_bank_xor;
  logic [4:0]  cfg_row_bits;
  logic [3:0]  cfg_col_bits;
  logic        out_valid, out_ready;
  logic [17:0] out_row;
  logic [10:0] out_col;
  logic [1:0]  out_bank, out_bgrp;

  always #2 clk = ~clk;

  drm_rcb_mapper i_drm_rcb_mapper (.*);

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int crow[17] = '{15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33};
  int orow[17] = '{14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33};
  int ccol[10] = '{3,4,5,14,19,23,24,25,26,27};
  int ocol[10] = '{3,4,5,6,7,8,9,10,11,12};
  int fcol[10] = '{3,4,5,7,8,9,10,11,12,13};

  logic [32:0] expq[$];
  bit          modeq[$];
  logic [32:0] held;
  bit          hold_prev = 0;

  function automatic logic [32:0] ref_map(logic [33:0] a, bit cl, bit fg, bit hx,
                                          int rb, int cb);
    logic [17:0] row = '0;
    logic [10:0] col = '0;
    logic [1:0]  ba, bg;
    for (int i = 0; i < 17; i++)
      if (i < rb) row[i] = a[cl ? crow[i] : orow[i]];
    for (int i = 0; i < 10; i++)
      if (i < cb) col[i] = a[cl ? ccol[i] : (fg ? fcol[i] : ocol[i])];
    col[10] = cl;
    if (cl) begin
      ba = {a[9], a[8]};
      bg = {a[7], a[6]};
      if (hx) begin ba ^= {a[28], a[22]}; bg ^= {a[21], a[20]}; end
    end else begin
      ba = {a[19], a[18]};
      bg = {a[17], fg ? a[6] : a[13]};
      if (hx) begin ba ^= {a[23], a[22]}; bg ^= {a[21], a[20]}; end
    end
    return {row, col, ba, bg};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [33:0] a, bit cl, bit fg, bit hx,
                      logic [4:0] rb, logic [3:0] cb, bit rdy);
    logic [32:0] act, exp;
    bit          emode;
    @(negedge clk);
    in_valid = v; in_addr = a; cfg_closed_page = cl; cfg_fine_grain = fg;
    cfg_bank_xor = hx; cfg_row_bits = rb; cfg_col_bits = cb; out_ready = rdy;
    #1;
    act = {out_row, out_col, out_bank, out_bgrp};
    if (hold_prev)
      chk(out_valid && act == held, "R11 hold", {out_valid, act}, {1'b1, held});
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(0, "R10 spurious out_valid", 1, 0);
      else begin
        exp = expq.pop_front(); emode = modeq.pop_front();
        chk(out_row == exp[32:15], emode ? "R1 row" : "R4 row", out_row, exp[32:15]);
        chk(out_col == exp[14:4], emode ? "R2 col" : "R5 col", out_col, exp[14:4]);
        chk(out_bank == exp[3:2], emode ? "R3 bank" : "R6 bank", out_bank, exp[3:2]);
        chk(out_bgrp == exp[1:0], emode ? "R3 group" : "R7 group", out_bgrp, exp[1:0]);
      end
    end
    chk(in_ready == (!out_valid || out_ready), "R10 ready rule", in_ready, !out_valid || out_ready);
    if (v && in_ready) begin
      exp = ref_map(a, cl, fg, hx, int'(rb), int'(cb));
      chk((exp[32:15] >> rb) == 0, "R8 model row mask", exp[32:15], 0);
      expq.push_back(exp); modeq.push_back(cl);
    end
    hold_prev = out_valid && !out_ready;
    held = act;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [33:0] ones = '1;
    void'($urandom(32'd7719));
    rst_n = 0; in_valid = 0; in_addr = '0; cfg_closed_page = 0; cfg_fine_grain = 0;
    cfg_bank_xor = 0; cfg_row_bits = 5'd13; cfg_col_bits = 4'd10; out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0, "R12 out_valid in reset", out_valid, 0);
    chk(in_ready == 1, "R12 in_ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1; #1;
    chk(out_valid == 0, "R12 out_valid after reset", out_valid, 0);

    // Directed corners: largest counts, row bit 17 and column limit (R8, R9).
    step(1, ones, 1, 0, 0, 5'd18, 4'd15, 1);
    step(1, ones, 0, 0, 0, 5'd18, 4'd15, 1);
    step(1, ones, 0, 1, 1, 5'd31, 4'd12, 1);
    // Hash-only addresses per policy (R3, R6, R7).
    step(1, 34'h0_1060_0000, 1, 0, 1, 5'd13, 4'd10, 1);
    step(1, 34'h0_00F0_0000, 0, 0, 1, 5'd13, 4'd10, 1);
    // Fine-grain must not change the closed-page map (R2).
    step(1, 34'h2_5A5A_5A5A, 1, 1, 0, 5'd16, 4'd10, 1);
    // Single bit 13 vs 6 in bank group (R7).
    step(1, 34'h0_0000_2040, 0, 0, 0, 5'd14, 4'd10, 1);
    step(1, 34'h0_0000_2040, 0, 1, 0, 5'd14, 4'd10, 1);
    // Small counts (R8, R9).
    step(1, ones, 0, 0, 0, 5'd13, 4'd3, 0);
    step(1, ones, 1, 0, 0, 5'd2, 4'd0, 0);
    step(0, '0, 0, 0, 0, 5'd13, 4'd10, 1);
    step(0, '0, 0, 0, 0, 5'd13, 4'd10, 1);

    for (int n = 0; n < 3000; n++) begin
      logic [33:0] a;
      logic [4:0]  rb;
      a  = {$urandom, $urandom};
      rb = ($urandom % 8 == 0) ? 5'($urandom) : 5'(13 + $urandom % 6);
      step(($urandom % 4) != 0, a, $urandom % 2, $urandom % 2, $urandom % 2,
           rb, 4'($urandom), ($urandom % 10) < 7);
    end

    for (int n = 0; n < 8; n++) step(0, '0, 0, 0, 0, 5'd13, 4'd10, 1);
    chk(expq.size() == 0, "R10 all accepted beats delivered", expq.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule